// File: doc/BRIEF.md
# Bus-Mapped MMC SPI Host Port

This block hangs off a simple 8-bit processor bus and drives up to two MMC cards in SPI mode. The bus sees two byte locations. One is a data port and one is a control byte. The control byte picks one of two serial clock rates and drives the select line of each card. A write to the data port sends that byte to the card. A read of the data port returns the byte captured by the transfer that came before. The read also launches a new transfer that sends all ones, so software can stream received bytes with back-to-back reads.

One byte takes many bus clocks to shift. The shifter therefore runs on its own once started, and the `busy` output shows when it is running. The two serial rates are set by parameters as half-period lengths in bus clocks. A fast setting stands for the doubled bus-phase clock and a slow setting for the divided one. The rate is taken when a transfer starts.

Top module: `mmc_spi_port`

## Requirements
- R1: Address 0 is the data port and address 1 is the control byte. Reading the control byte returns bit 7 (rate) and bits 1:0 (card selects), with bits 6:2 always reading 0. Writing 1s to bits 6:2 has no effect.
- R2: A data-port write while idle starts a transfer that shifts the written byte out on `mosi`, MSB first, over eight `sclk` pulses. `mosi` changes only when `sclk` falls or when a transfer starts.
- R3: `miso` is sampled on each rising `sclk` edge, MSB first. The byte is held after the eighth pulse until a later transfer ends.
- R4: A data-port read returns the byte captured by the most recently completed transfer. If the port is idle, the read also starts a transfer that holds `mosi` at 1 for all eight bits, so the card receives 0xFF.
- R5: Control bit 7 = 0 selects the fast rate (`sclk` half period of FAST_HALF clocks) and 1 selects the slow rate (SLOW_HALF clocks). `busy` stays high for exactly 16 half periods per transfer.
- R6: `cs_n[0]` is the inverse of control bit 0 and `cs_n[1]` is the inverse of control bit 1. Both take effect one clock after the control write.
- R7: After reset, the control byte reads 0, both `cs_n` lines are 1, `busy` is 0, `sclk` is 0, `mosi` is 1 and the data port reads 0.
- R8: A data-port read or write that arrives while `busy` is high is ignored. It does not restart or lengthen the transfer and does not change the bits sent.
- R9: While idle, `sclk` is held at 0 and `mosi` at 1.
- R10: A control write during a transfer changes the card selects at once, but the rate of the running transfer stays the one taken at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one clock per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = data port, 1 = control byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed location |
| miso | input | 1 | Serial data from card |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to card, idles high |
| cs_n | output | 2 | Active-low card selects |
| busy | output | 1 | Transfer in progress |

## Verification
The bench builds the port with FAST_HALF = 2 and SLOW_HALF = 8 rather than the default slow value. This keeps a slow transfer down to 128 clocks, so runs at both rates fit in a short test. The two rates still differ enough that a transfer timed at the wrong rate gives a clearly wrong `busy` length. With FAST_HALF at 2 each `sclk` level lasts more than one clock. That lets the bench tell a `mosi` change on the falling edge from one on the rising edge. It also lets it land an access in the middle of a transfer to test the ignored-access and rate-latch rules.

// File: rtl/mmc_spi_pkg.sv
package mmc_spi_pkg;

    localparam int BYTE_W    = 8;
    localparam int CARD_CNT  = 2;
    localparam int BIT_CNT_W = $clog2(BYTE_W);

    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_CTRL = 1'b1;

    localparam int RATE_BIT = 7;

    localparam logic [BYTE_W-1:0] FILL_BYTE = '1;

    typedef struct packed {
        logic                slow;
        logic [CARD_CNT-1:0] sel;
    } ctrl_t;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LOW,
        SH_HIGH
    } sh_state_e;

    typedef struct packed {
        logic              go;
        logic [BYTE_W-1:0] tx;
    } start_req_t;

    function automatic logic [BYTE_W-1:0] ctrl_to_byte(input ctrl_t c);
        logic [BYTE_W-1:0] b;
        b                 = '0;
        b[RATE_BIT]       = c.slow;
        b[CARD_CNT-1:0]   = c.sel;
        return b;
    endfunction

    function automatic ctrl_t byte_to_ctrl(input logic [BYTE_W-1:0] b);
        ctrl_t c;
        c.slow = b[RATE_BIT];
        c.sel  = b[CARD_CNT-1:0];
        return c;
    endfunction

endpackage

// File: rtl/mmc_spi_bus_dec.sv
module mmc_spi_bus_dec
    import mmc_spi_pkg::*;
(
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic              bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              busy,
    input  logic [BYTE_W-1:0] rx_hold,
    input  ctrl_t             ctrl,
    output logic              ctrl_we,
    output start_req_t        start_req,
    output logic [BYTE_W-1:0] bus_rdata
);

    logic data_acc;

    always_comb begin
        data_acc     = bus_sel && (bus_addr == ADDR_DATA);
        ctrl_we      = bus_sel && bus_we && (bus_addr == ADDR_CTRL);
        start_req.go = data_acc && !busy;
        start_req.tx = bus_we ? bus_wdata : FILL_BYTE;
        bus_rdata    = (bus_addr == ADDR_CTRL) ? ctrl_to_byte(ctrl) : rx_hold;
    end

endmodule

// File: rtl/mmc_spi_ctrl_reg.sv
module mmc_spi_ctrl_reg
    import mmc_spi_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ctrl_we,
    input  logic [BYTE_W-1:0]   wdata,
    output ctrl_t               ctrl,
    output logic [CARD_CNT-1:0] cs_n
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (ctrl_we) begin
            ctrl <= byte_to_ctrl(wdata);
        end
    end

    for (genvar g = 0; g < CARD_CNT; g++) begin : g_cs
        assign cs_n[g] = ~ctrl.sel[g];
    end

endmodule

// File: rtl/mmc_spi_rate_tick.sv
module mmc_spi_rate_tick #(
    parameter int FAST_HALF = 2,
    parameter int SLOW_HALF = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic slow,
    input  logic busy,
    output logic tick
);

    localparam int CW = (SLOW_HALF > 1) ? $clog2(SLOW_HALF) : 1;
    localparam logic [CW-1:0] FAST_LIM = CW'(FAST_HALF - 1);
    localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_HALF - 1);

    logic [CW-1:0] cnt;
    logic          slow_l;
    logic [CW-1:0] lim;

    assign lim  = slow_l ? SLOW_LIM : FAST_LIM;
    assign tick = busy && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            slow_l <= 1'b0;
        end else if (start) begin
            cnt    <= '0;
            slow_l <= slow;
        end else if (busy) begin
            cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mmc_spi_shifter.sv
module mmc_spi_shifter
    import mmc_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  start_req_t        start_req,
    input  logic              tick,
    input  logic              miso,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    output logic [BYTE_W-1:0] rx_hold
);

    sh_state_e            state;
    logic [BYTE_W-1:0]    tx_sh;
    logic [BYTE_W-1:0]    rx_sh;
    logic [BIT_CNT_W-1:0] bit_n;

    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SH_IDLE;
            tx_sh   <= '0;
            rx_sh   <= '0;
            rx_hold <= '0;
            bit_n   <= '0;
        end else begin
            case (state)
                SH_IDLE: begin
                    if (start_req.go) begin
                        tx_sh <= start_req.tx;
                        bit_n <= '0;
                        state <= SH_LOW;
                    end
                end
                SH_LOW: begin
                    if (tick) begin
                        rx_sh <= {rx_sh[BYTE_W-2:0], miso};
                        state <= SH_HIGH;
                    end
                end
                SH_HIGH: begin
                    if (tick) begin
                        if (bit_n == LAST_BIT) begin
                            rx_hold <= rx_sh;
                            state   <= SH_IDLE;
                        end else begin
                            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b1};
                            bit_n <= bit_n + 1'b1;
                            state <= SH_LOW;
                        end
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

    assign busy = (state != SH_IDLE);
    assign sclk = (state == SH_HIGH);
    assign mosi = busy ? tx_sh[BYTE_W-1] : 1'b1;

endmodule

// File: rtl/mmc_spi_port.sv
module mmc_spi_port
    import mmc_spi_pkg::*;
#(
    parameter int FAST_HALF = 2,
    parameter int SLOW_HALF = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_sel,
    input  logic       bus_we,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic [1:0] cs_n,
    output logic       busy
);

    ctrl_t             ctrl;
    logic              ctrl_we;
    start_req_t        start_req;
    logic [BYTE_W-1:0] rx_hold;
    logic              tick;

    mmc_spi_bus_dec u_dec (
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .rx_hold   (rx_hold),
        .ctrl      (ctrl),
        .ctrl_we   (ctrl_we),
        .start_req (start_req),
        .bus_rdata (bus_rdata)
    );

    mmc_spi_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ctrl_we (ctrl_we),
        .wdata   (bus_wdata),
        .ctrl    (ctrl),
        .cs_n    (cs_n)
    );

    mmc_spi_rate_tick #(
        .FAST_HALF (FAST_HALF),
        .SLOW_HALF (SLOW_HALF)
    ) u_tick (
        .clk   (clk),
        .rst   (rst),
        .start (start_req.go),
        .slow  (ctrl.slow),
        .busy  (busy),
        .tick  (tick)
    );

    mmc_spi_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .tick      (tick),
        .miso      (miso),
        .busy      (busy),
        .sclk      (sclk),
        .mosi      (mosi),
        .rx_hold   (rx_hold)
    );

endmodule

// File: rtl/mmc_spi_port_chk.sv
module mmc_spi_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_sel,
    input logic       bus_we,
    input logic       bus_addr,
    input logic [7:0] bus_wdata,
    input logic       busy,
    input logic       sclk,
    input logic       mosi,
    input logic [1:0] cs_n
);

    a_r6_cs_follow: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && bus_addr) |=> (cs_n == ~$past(bus_wdata[1:0])));

    a_r9_idle_lines: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!sclk && mosi));

    a_r8_start_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(bus_sel && !bus_addr));

    a_r2_mosi_on_fall: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$fell(sclk)) |-> $stable(mosi));

    a_r9_sclk_quiet: assert property (@(posedge clk) disable iff (rst)
        !$stable(sclk) |-> (busy || $past(busy)));

endmodule

bind mmc_spi_port mmc_spi_port_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .busy      (busy),
    .sclk      (sclk),
    .mosi      (mosi),
    .cs_n      (cs_n)
);

// File: tb/mmc_spi_port_tb_top.sv
module mmc_spi_port_tb_top;

    localparam int FH = 2;
    localparam int SH = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       miso = 1'b1;
    logic       sclk;
    logic       mosi;
    logic [1:0] cs_n;
    logic       busy;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic       run_on = 1'b0;
    logic [7:0] model_ctrl = 8'h00;
    logic [7:0] prev_rx = 8'h00;
    logic [7:0] card_sh = 8'hFF;
    logic [7:0] card_rx = 8'h00;

    always #4 clk = ~clk;

    mmc_spi_port #(.FAST_HALF(FH), .SLOW_HALF(SH)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .cs_n      (cs_n),
        .busy      (busy)
    );

    // card model: captures on rising sclk, shifts out on falling sclk
    always @(posedge sclk) card_rx = {card_rx[6:0], mosi};
    always @(negedge sclk) begin
        card_sh = {card_sh[6:0], 1'b1};
        miso    = card_sh[7];
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the behavioural model
    always @(posedge clk) begin
        #2;
        if (run_on) begin
            chk(cs_n == ~model_ctrl[1:0], "R6", cs_n, ~model_ctrl[1:0]);
            if (!busy) chk(!sclk && mosi, "R9", {sclk, mosi}, 2'b01);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic write_ctrl(input logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 1'b1; bus_wdata = v;
        model_ctrl = v & 8'h83;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic xfer(input logic rd, input logic [7:0] tx, input logic [7:0] cout,
                        input int exp_len, input int mid_kind, input logic [7:0] mid_val,
                        input string len_tag, input string dat_tag);
        int cnt;
        card_sh = cout; miso = cout[7]; card_rx = 8'h00;
        @(negedge clk);
        bus_sel = 1'b1; bus_we = !rd; bus_addr = 1'b0; bus_wdata = tx;
        #1;
        if (rd) chk(bus_rdata == prev_rx, "R4", bus_rdata, prev_rx);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        cnt = 0;
        while (busy && cnt < 5000) begin
            cnt++;
            if (cnt == 3 && mid_kind == 1) begin
                bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 1'b0; bus_wdata = mid_val;
            end else if (cnt == 3 && mid_kind == 2) begin
                bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 1'b1; bus_wdata = mid_val;
                model_ctrl = mid_val & 8'h83;
            end else if (cnt == 5 && mid_kind == 3) begin
                bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 1'b0;
            end else begin
                bus_sel = 1'b0; bus_we = 1'b0; bus_addr = 1'b0;
            end
            @(negedge clk);
        end
        bus_sel = 1'b0; bus_we = 1'b0;
        chk(cnt == exp_len, len_tag, cnt, exp_len);
        chk(card_rx == (rd ? 8'hFF : tx), dat_tag, card_rx, rd ? 8'hFF : tx);
        prev_rx = cout;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        run_on = 1'b1;
        @(negedge clk);
        // R7 reset state
        chk(cs_n == 2'b11, "R7", cs_n, 2'b11);
        chk(!busy && !sclk && mosi, "R7", {busy, sclk, mosi}, 3'b001);
        bus_addr = 1'b1; #1;
        chk(bus_rdata == 8'h00, "R7", bus_rdata, 8'h00);
        bus_addr = 1'b0; #1;
        chk(bus_rdata == 8'h00, "R7", bus_rdata, 8'h00);

        // R2 / R5 fast write, R3 capture
        xfer(1'b0, 8'hA5, 8'h3C, 16*FH, 0, 8'h00, "R5", "R2");
        // R4 read returns previous byte, sends 0xFF
        xfer(1'b1, 8'h00, 8'h96, 16*FH, 0, 8'h00, "R5", "R4");
        xfer(1'b1, 8'h00, 8'h5A, 16*FH, 0, 8'h00, "R5", "R3");

        // R1 reserved bits, R6 selects
        write_ctrl(8'hFD);
        @(negedge clk);
        bus_addr = 1'b1; #1;
        chk(bus_rdata == 8'h81, "R1", bus_rdata, 8'h81);
        chk(cs_n == 2'b10, "R6", cs_n, 2'b10);
        bus_addr = 1'b0;

        // R5 slow rate
        xfer(1'b0, 8'h71, 8'hC3, 16*SH, 0, 8'h00, "R5", "R2");
        // R8 data write while busy is ignored
        xfer(1'b0, 8'hE8, 8'h0F, 16*SH, 1, 8'h12, "R8", "R8");
        // R8 data read while busy is ignored
        xfer(1'b0, 8'h4B, 8'hA0, 16*SH, 3, 8'h00, "R8", "R8");
        // R10 rate held when control changes mid transfer
        xfer(1'b0, 8'h2D, 8'h77, 16*SH, 2, 8'h02, "R10", "R10");
        chk(cs_n == 2'b01, "R10", cs_n, 2'b01);
        // next transfer uses new fast rate; read returns 0x77
        xfer(1'b1, 8'h00, 8'h81, 16*FH, 0, 8'h00, "R5", "R4");
        bus_addr = 1'b0; #1;
        chk(bus_rdata == 8'h81, "R3", bus_rdata, 8'h81);

        run_on = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule